// File: doc/BRIEF.md
# Hazard Stall and Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It decides, every cycle, whether the front of the pipe must freeze for a load-use hazard, and whether younger instructions must be squashed because a branch resolved as taken or because the execute stage raised an arithmetic overflow. All of its control outputs are combinational from the current inputs and one state register. The datapath registers, the PC multiplexer and the operand forwarding logic consume these outputs in the same cycle.

A four-state machine drives the outputs. The state holds the event that the controller acted on in the previous cycle:
- `HS_RUN`: no event.
- `HS_STALL`: load-use freeze.
- `HS_BRFLUSH`: taken-branch squash.
- `HS_EXCFLUSH`: overflow squash and redirect.

The event of the current cycle is the next state, so every transition goes from the previous event to the current one. Any state moves to `HS_EXCFLUSH` on overflow. Otherwise any state moves to `HS_BRFLUSH` on a taken branch. A state other than `HS_STALL` moves to `HS_STALL` on a load-use match. Every other case moves to `HS_RUN`. The move from `HS_STALL` to `HS_STALL` is excluded, so a freeze never lasts longer than one cycle. Reset forces `HS_RUN`.

Top module: `hzc_hazard_ctrl`

## Requirements
- R1: A load-use match sets `pc_we`=0, `ifid_we`=0 and `ctrl_bubble`=1, with all three flush outputs at 0 and `pc_sel`=00. A match means that `idex_mem_rd`=1 and `idex_rt` equals `ifid_rs` or `ifid_rt`.
- R2: When `idex_rt` is register 0, no stall occurs, whatever the source fields hold.
- R3: In the cycle after a stall, no stall is requested, even if the match is still present.
- R4: When `mem_br_taken`=1 and `ex_ovf`=0, the outputs are:
  - `if_flush`=1, `id_flush`=1 and `ex_flush`=1.
  - `pc_sel`=01 (branch target).
  - `pc_we`=1 and `ifid_we`=1.
  - `ctrl_bubble`=0.
- R5: When `ex_ovf`=1, the outputs are:
  - all three flush outputs at 1.
  - `pc_sel`=10 (exception vector).
  - `pc_we`=1 and `ifid_we`=1.
  - `ctrl_bubble`=0.
  
  `exc_vec` always reads 0x40000040.
- R6: Overflow outranks a taken branch, and a taken branch outranks a load-use match. A load-use match is never acted on while a flush is active.
- R7: With no event, the outputs are `pc_we`=1, `ifid_we`=1, `ctrl_bubble`=0, all flush outputs at 0 and `pc_sel`=00. This includes the case where the register fields match but `idex_mem_rd`=0.
- R8: While `rst_n` is low, the outputs take the no-event values whatever the inputs are. The first load-use match after reset stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_rs | input | 5 | First source register of the instruction being decoded |
| ifid_rt | input | 5 | Second source register of the instruction being decoded |
| idex_mem_rd | input | 1 | Instruction in execute performs a memory read |
| idex_rt | input | 5 | Load destination register of the instruction in execute |
| mem_br_taken | input | 1 | Branch in the memory stage resolved as taken |
| ex_ovf | input | 1 | Overflow raised by the ALU in execute |
| pc_we | output | 1 | PC update enable |
| ifid_we | output | 1 | Decode pipeline register write enable |
| ctrl_bubble | output | 1 | Select zero control into the execute register (stall bubble) |
| if_flush | output | 1 | Load a nop into the decode register |
| id_flush | output | 1 | Zero the control entering the execute register |
| ex_flush | output | 1 | Zero the control entering the memory register |
| pc_sel | output | 2 | Next PC source: 00 sequential, 01 branch target, 10 exception vector |
| exc_vec | output | 32 | Exception handler address |

## Verification
The assertions assume two things about the pipeline around the block. First, `rst_n` is released while the inputs are quiet. Second, the event inputs are meaningful only when `rst_n` is high, so no check looks at them during reset except the reset-quiet check. The stall-length property relies on the design's own one-cycle suppression rather than on the surrounding pipeline clearing `idex_mem_rd`. The stimulus therefore deliberately holds a match across two cycles to exercise that suppression. Inputs change only on the falling clock edge, so each combinational decision is settled well before the state register samples it.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int PCSEL_W = 2;

    typedef enum logic [1:0] {
        HS_RUN      = 2'd0,
        HS_STALL    = 2'd1,
        HS_BRFLUSH  = 2'd2,
        HS_EXCFLUSH = 2'd3
    } hz_state_e;

    typedef enum logic [PCSEL_W-1:0] {
        PCS_SEQ    = 2'd0,
        PCS_BRANCH = 2'd1,
        PCS_EXCVEC = 2'd2
    } pc_src_e;

endpackage

// File: rtl/hzc_loaduse_detect.sv
module hzc_loaduse_detect #(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic [NSRC-1:0][REG_AW-1:0] src_regs,
    input  logic                        ld_valid,
    input  logic [REG_AW-1:0]           ld_dest,
    output logic                        hit
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] src_eq;

    // One comparator for each source field of the decoding instruction.
    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign src_eq[s] = (src_regs[s] == ld_dest);
    end

    // Register zero is hard-wired and never carries a dependence.
    assign hit = ld_valid && (ld_dest != ZERO_REG) && (|src_eq);

endmodule

// File: rtl/hzc_sequencer.sv
module hzc_sequencer
    import hzc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lu_hit,
    input  logic               br_taken,
    input  logic               ovf,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               ctrl_bubble,
    output logic               if_flush,
    output logic               id_flush,
    output logic               ex_flush,
    output logic [PCSEL_W-1:0] pc_sel
);

    hz_state_e state_q;
    hz_state_e evt;

    // Event chosen this cycle, in priority order; becomes the next state.
    always_comb begin
        if (!rst_n)                          evt = HS_RUN;
        else if (ovf)                        evt = HS_EXCFLUSH;
        else if (br_taken)                   evt = HS_BRFLUSH;
        else if (lu_hit && state_q != HS_STALL) evt = HS_STALL;
        else                                 evt = HS_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_RUN;
        else        state_q <= evt;
    end

    always_comb begin
        pc_we       = 1'b1;
        ifid_we     = 1'b1;
        ctrl_bubble = 1'b0;
        if_flush    = 1'b0;
        id_flush    = 1'b0;
        ex_flush    = 1'b0;
        pc_sel      = PCS_SEQ;
        unique case (evt)
            HS_RUN: begin
            end
            HS_STALL: begin
                pc_we       = 1'b0;
                ifid_we     = 1'b0;
                ctrl_bubble = 1'b1;
            end
            HS_BRFLUSH: begin
                if_flush = 1'b1;
                id_flush = 1'b1;
                ex_flush = 1'b1;
                pc_sel   = PCS_BRANCH;
            end
            HS_EXCFLUSH: begin
                if_flush = 1'b1;
                id_flush = 1'b1;
                ex_flush = 1'b1;
                pc_sel   = PCS_EXCVEC;
            end
            default: begin
            end
        endcase
    end

    // R1: an accepted load-use match freezes the front end and inserts a bubble.
    p_stall_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_hit && !ovf && !br_taken && state_q != HS_STALL)
            |-> (!pc_we && !ifid_we && ctrl_bubble && !if_flush && pc_sel == PCS_SEQ));

    // R3: a freeze never spans two consecutive cycles.
    p_stall_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> pc_we);

    // R4: a taken branch squashes the three younger stages.
    p_branch_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !ovf) |-> (if_flush && id_flush && ex_flush && pc_sel == PCS_BRANCH));

    // R5: overflow squashes and selects the handler address.
    p_exc_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (if_flush && id_flush && ex_flush && pc_sel == PCS_EXCVEC && pc_we));

    // R6: no freeze is ever combined with a squash.
    p_flush_no_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_flush || ex_flush) |-> (pc_we && ifid_we && !ctrl_bubble));

    // R7: without any event, every output rests.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lu_hit && !br_taken && !ovf)
            |-> (pc_we && ifid_we && !ctrl_bubble && !id_flush && pc_sel == PCS_SEQ));

    // R8: reset holds the outputs at their resting values.
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r8: assert (pc_we && ifid_we && !ctrl_bubble && !if_flush
                                      && !id_flush && !ex_flush && pc_sel == PCS_SEQ);
        end
    end

endmodule

// File: rtl/hzc_hazard_ctrl.sv
module hzc_hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int          REG_AW  = 5,
    parameter int          PC_W    = 32,
    parameter logic [31:0] EXC_VEC = 32'h4000_0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  ifid_rs,
    input  logic [REG_AW-1:0]  ifid_rt,
    input  logic               idex_mem_rd,
    input  logic [REG_AW-1:0]  idex_rt,
    input  logic               mem_br_taken,
    input  logic               ex_ovf,
    output logic               pc_we,
    output logic               ifid_we,
    output logic               ctrl_bubble,
    output logic               if_flush,
    output logic               id_flush,
    output logic               ex_flush,
    output logic [PCSEL_W-1:0] pc_sel,
    output logic [PC_W-1:0]    exc_vec
);

    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] srcs;
    logic                        lu_hit;

    assign srcs    = {ifid_rt, ifid_rs};
    assign exc_vec = EXC_VEC[PC_W-1:0];

    hzc_loaduse_detect #(
        .REG_AW (REG_AW),
        .NSRC   (NSRC)
    ) u_detect (
        .src_regs (srcs),
        .ld_valid (idex_mem_rd),
        .ld_dest  (idex_rt),
        .hit      (lu_hit)
    );

    hzc_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .lu_hit      (lu_hit),
        .br_taken    (mem_br_taken),
        .ovf         (ex_ovf),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .ctrl_bubble (ctrl_bubble),
        .if_flush    (if_flush),
        .id_flush    (id_flush),
        .ex_flush    (ex_flush),
        .pc_sel      (pc_sel)
    );

    // R2: a load into register zero never freezes the pipeline.
    p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == '0) |-> pc_we);

endmodule

// File: tb/tb_hzc_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hzc_hazard_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ifid_rs = '0, ifid_rt = '0, idex_rt = '0;
    logic       idex_mem_rd = 1'b0, mem_br_taken = 1'b0, ex_ovf = 1'b0;
    logic       pc_we, ifid_we, ctrl_bubble, if_flush, id_flush, ex_flush;
    logic [1:0] pc_sel;
    logic [31:0] exc_vec;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hzc_hazard_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .idex_mem_rd(idex_mem_rd), .idex_rt(idex_rt), .mem_br_taken(mem_br_taken),
        .ex_ovf(ex_ovf), .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_bubble(ctrl_bubble),
        .if_flush(if_flush), .id_flush(id_flush), .ex_flush(ex_flush),
        .pc_sel(pc_sel), .exc_vec(exc_vec)
    );

    // Stimulus fields: rs, rt, mem_rd, idex_rt, br, ovf.
    // Expected fields: pc_we, ifid_we, bubble, if_flush, id_flush, ex_flush, pc_sel.
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {5'd1, 5'd2, 1'b0, 5'd1,  1'b0, 1'b0, 8'b1100_0000}, // R7: rd low, no stall
        {5'd3, 5'd4, 1'b1, 5'd3,  1'b0, 1'b0, 8'b0010_0000}, // R1: rs match
        {5'd3, 5'd4, 1'b1, 5'd3,  1'b0, 1'b0, 8'b1100_0000}, // R3: held match
        {5'd5, 5'd7, 1'b1, 5'd7,  1'b0, 1'b0, 8'b0010_0000}, // R1: rt match
        {5'd5, 5'd7, 1'b0, 5'd7,  1'b0, 1'b0, 8'b1100_0000}, // R7
        {5'd0, 5'd0, 1'b1, 5'd0,  1'b0, 1'b0, 8'b1100_0000}, // R2: register 0
        {5'd1, 5'd2, 1'b0, 5'd6,  1'b1, 1'b0, 8'b1101_1101}, // R4: branch
        {5'd9, 5'd2, 1'b1, 5'd9,  1'b1, 1'b0, 8'b1101_1101}, // R6: branch over stall
        {5'd1, 5'd2, 1'b0, 5'd6,  1'b0, 1'b1, 8'b1101_1110}, // R5: overflow
        {5'd9, 5'd2, 1'b1, 5'd9,  1'b1, 1'b1, 8'b1101_1110}, // R6: overflow wins
        {5'd9, 5'd2, 1'b1, 5'd9,  1'b0, 1'b0, 8'b0010_0000}, // R1: stall after flush
        {5'd9, 5'd11,1'b1, 5'd10, 1'b0, 1'b0, 8'b1100_0000}  // R7: no field match
    };

    function automatic string row_tag(int i);
        case (i)
            1, 3, 10: return "R1";
            2:        return "R3";
            5:        return "R2";
            6:        return "R4";
            8:        return "R5";
            7, 9:     return "R6";
            default:  return "R7";
        endcase
    endfunction

    function automatic logic [7:0] outs();
        return {pc_we, ifid_we, ctrl_bubble, if_flush, id_flush, ex_flush, pc_sel};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(logic [4:0] rs, logic [4:0] rt, logic rd, logic [4:0] lrt,
                         logic br, logic ov);
        ifid_rs = rs; ifid_rt = rt; idex_mem_rd = rd; idex_rt = lrt;
        mem_br_taken = br; ex_ovf = ov;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R8: reset overrides a live match and a branch.
        drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        #5 check("R8", {24'd0, outs()}, {24'd0, 8'b1100_0000});
        @(negedge clk);
        drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        #5 check("R5", exc_vec, 32'h4000_0040);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][25:21], VEC[i][20:16], VEC[i][15], VEC[i][14:10],
                  VEC[i][9], VEC[i][8]);
            #5 check(row_tag(i), {24'd0, outs()}, {24'd0, VEC[i][7:0]});
        end

        // R6: a branch arriving in the cycle after a stall flushes.
        @(negedge clk); drive(5'd8, 5'd1, 1'b1, 5'd8, 1'b0, 1'b0);
        #5 check("R1", {24'd0, outs()}, {24'd0, 8'b0010_0000});
        @(negedge clk); drive(5'd8, 5'd1, 1'b1, 5'd8, 1'b1, 1'b0);
        #5 check("R6", {24'd0, outs()}, {24'd0, 8'b1101_1101});

        // R8: after a second reset the first match stalls at once.
        @(negedge clk); drive(5'd8, 5'd1, 1'b1, 5'd8, 1'b0, 1'b0);
        #5 check("R1", {24'd0, outs()}, {24'd0, 8'b0010_0000});
        rst_n = 1'b0;
        #2 check("R8", {24'd0, outs()}, {24'd0, 8'b1100_0000});
        @(negedge clk); drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); drive(5'd4, 5'd6, 1'b1, 5'd6, 1'b0, 1'b0);
        #5 check("R8", {24'd0, outs()}, {24'd0, 8'b0010_0000});

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule